// File: doc/BRIEF.md
# Oversampled Serial Receiver with Three-Sample Voting

This block receives asynchronous serial characters on a single idle-high line. A programmable divisor turns the system clock into a tick that runs sixteen times per bit period. A falling edge on the line opens a frame, and from then on the block counts ticks to locate the centre of each bit. Around that centre it takes three samples, one tick apart, for every bit of the frame: the start bit, each data bit, the optional parity bit and the stop bit. The bit value is the majority of the three samples. If the three samples of any bit disagree, the noise flag is set for that character.

Each character has one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Parity can be turned off, or set to even or odd. The received byte and its parity, framing and noise flags are presented together with a one-cycle strobe. They are held until the next character is delivered. The intended rate is 57,600 bit/s. The divisor is chosen so that sixteen ticks make one bit at the system clock in use.

Top module: `serial_rx_vote`

## Requirements
- R1: While reset is held, and until the first character is delivered, `rx_valid` is 0 and `rx_data`, `parity_err`, `frame_err` and `noise_err` are all 0.
- R2: One tick lasts `baud_div` system clocks and one bit lasts 16 ticks. Characters are received correctly at any divisor of 2 or more, for example at 4 and at 6.
- R3: A high-to-low transition on the idle line opens a frame. If the voted start bit is high, the frame is dropped without any strobe, and the receiver waits for the next falling edge.
- R4: Eight data bits follow the start bit, least significant first. The byte appears on `rx_data` together with a `rx_valid` pulse exactly one clock wide.
- R5: Each bit is sampled on the 7th, 8th and 9th tick of its bit period, and its value is the majority of those three samples.
- R6: `noise_err` is 1 on delivery when, for any bit of that character (start, data, parity or stop), the three samples are not all equal. Otherwise it is 0.
- R7: When `parity_en` is 1, a parity bit follows the data. `parity_odd` = 0 requires an even number of ones over the data and parity bits, and `parity_odd` = 1 requires an odd number. `parity_err` reports a violation. When `parity_en` is 0, no parity bit is expected and `parity_err` is 0.
- R8: A stop bit that votes low sets `frame_err`, and the byte is still delivered with its strobe.
- R9: `rx_data` and the three error flags change only in the cycle in which `rx_valid` is 1, and hold their values between strobes.
- R10: Delivery happens at the third sample of the stop bit. A start edge that comes immediately after the stop bit period ends, with no idle time, is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_div | input | 16 | System clocks per tick (1/16 bit) |
| parity_en | input | 1 | 1 = a parity bit follows the data |
| parity_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe when a character is delivered |
| parity_err | output | 1 | Parity mismatch of the delivered character |
| frame_err | output | 1 | Stop bit of the delivered character voted low |
| noise_err | output | 1 | Some bit of the delivered character had disagreeing samples |

## Verification
The delivery strobe has to carry the frame-level noise result and the stop-bit verdict in the same cycle. The third stop sample decides both the framing flag and the last contribution to the noise flag. The bench provokes this by glitching a single sample of the stop bit, and separately by holding the stop bit low. It then judges the byte and all three flags against the queued expectation at that one strobe. A glitch across two samples of a data bit checks that the vote really flips the bit while the noise flag still rises. A short false start followed by a normal frame shows that an aborted frame leaves no stray strobe in the queue.

// File: rtl/srx_pkg.sv
// Shared types for the voting serial receiver.
package srx_pkg;
    // Frame position of the receiver.
    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_phase_e;
endpackage

// File: rtl/srx_tick_gen.sv
// Tick generator: produces a one-clock pulse every `div` clocks.
// Assumes: a divisor of 0 behaves as 1; `restart` realigns the count to zero.
module srx_tick_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    // Last count value of one tick period.
    always_comb lim = (div == '0) ? '0 : div - DIV_W'(1);

    assign tick = (cnt == lim);

    // Count clocks, wrapping at the tick or on restart.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (restart || tick) cnt <= '0;
        else                     cnt <= cnt + DIV_W'(1);
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && div > DIV_W'(1)) |=> (!tick || div <= DIV_W'(1))); // R2
endmodule

// File: rtl/srx_vote3.sv
// Three-sample voter: holds the first two samples of a bit and, on the
// third sampling tick, reports the majority value and a disagreement flag.
// Assumes: the caller's sub-tick counter advances by one on each tick.
module srx_vote3 #(
    parameter int SUB_W = 4,
    parameter int FIRST = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [SUB_W-1:0] sub,
    input  logic             line,
    output logic             done,
    output logic             bit_val,
    output logic             noise
);
    logic s0, s1;

    // Capture the first and second samples of the bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s0 <= 1'b1;
            s1 <= 1'b1;
        end else if (tick) begin
            if (sub == SUB_W'(FIRST))     s0 <= line;
            if (sub == SUB_W'(FIRST + 1)) s1 <= line;
        end
    end

    // Vote with the live third sample.
    always_comb begin
        done    = tick && (sub == SUB_W'(FIRST + 2));
        bit_val = (s0 & s1) | (s0 & line) | (s1 & line);
        noise   = !((s0 == s1) && (s1 == line));
    end
endmodule

// File: rtl/serial_rx_vote.sv
// Serial receiver top: synchroniser, start detection, frame sequencing,
// data assembly, parity/stop checks and output registers.
// Assumes: 16 ticks per bit, 8 data bits LSB first, one stop bit.
module serial_rx_vote #(
    parameter int DIV_W     = 16,
    parameter int DATA_BITS = 8,
    parameter int OSR       = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     baud_div,
    input  logic                 parity_en,
    input  logic                 parity_odd,
    input  logic                 rxd,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_valid,
    output logic                 parity_err,
    output logic                 frame_err,
    output logic                 noise_err
);
    import srx_pkg::*;

    localparam int SUB_W  = $clog2(OSR);
    localparam int SAMP0  = OSR / 2 - 2;
    localparam int CNT_W  = $clog2(DATA_BITS + 1);

    logic                 sync_a, line_s, line_prev;
    rx_phase_e            phase;
    logic [SUB_W-1:0]     sub;
    logic [CNT_W-1:0]     bitcnt;
    logic [DATA_BITS-1:0] shreg;
    logic                 par_bit, noise_acc;
    logic                 tick, start_edge, bit_end;
    logic                 v_done, v_bit, v_noise;

    // Two-flop synchroniser plus one delay for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a    <= 1'b1;
            line_s    <= 1'b1;
            line_prev <= 1'b1;
        end else begin
            sync_a    <= rxd;
            line_s    <= sync_a;
            line_prev <= line_s;
        end
    end

    // Start condition and end-of-bit decode.
    always_comb begin
        start_edge = (phase == RX_IDLE) && line_prev && !line_s;
        bit_end    = tick && (sub == SUB_W'(OSR - 1));
    end

    srx_tick_gen #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(start_edge),
        .div(baud_div), .tick(tick)
    );

    srx_vote3 #(.SUB_W(SUB_W), .FIRST(SAMP0)) u_vote (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sub(sub), .line(line_s),
        .done(v_done), .bit_val(v_bit), .noise(v_noise)
    );

    // Frame sequencer, data assembly and delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= RX_IDLE;
            sub        <= '0;
            bitcnt     <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            noise_acc  <= 1'b0;
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            noise_err  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (phase == RX_IDLE) begin
                if (start_edge) begin
                    phase     <= RX_START;
                    sub       <= '0;
                    bitcnt    <= '0;
                    noise_acc <= 1'b0;
                end
            end else begin
                if (tick) sub <= sub + SUB_W'(1);
                if (v_done) begin
                    noise_acc <= noise_acc | v_noise;
                    case (phase)
                        RX_START: if (v_bit) phase <= RX_IDLE;
                        RX_DATA: begin
                            shreg  <= {v_bit, shreg[DATA_BITS-1:1]};
                            bitcnt <= bitcnt + CNT_W'(1);
                        end
                        RX_PAR:  par_bit <= v_bit;
                        RX_STOP: begin
                            rx_valid   <= 1'b1;
                            rx_data    <= shreg;
                            frame_err  <= !v_bit;
                            noise_err  <= noise_acc | v_noise;
                            parity_err <= parity_en &&
                                          ((^shreg ^ par_bit) != parity_odd);
                            phase      <= RX_IDLE;
                        end
                        default: ;
                    endcase
                end else if (bit_end) begin
                    case (phase)
                        RX_START: phase <= RX_DATA;
                        RX_DATA:
                            if (bitcnt == CNT_W'(DATA_BITS))
                                phase <= parity_en ? RX_PAR : RX_STOP;
                        RX_PAR:  phase <= RX_STOP;
                        default: ;
                    endcase
                end
            end
        end
    end

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R4
    AST_HOLD_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> ($stable(rx_data) && $stable(frame_err) && $stable(noise_err))); // R9
    AST_NO_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(parity_en)) |-> !parity_err); // R7
    AST_VALID_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> ($past(phase) == RX_STOP)); // R10
endmodule

// File: tb/serial_rx_vote_test.sv
// Scoreboard bench: the send task queues the expected character, the
// monitor pops and compares on every delivery strobe.
module serial_rx_vote_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] baud_div = 16'd4;
    logic        parity_en = 1'b0;
    logic        parity_odd = 1'b0;
    logic        rxd = 1'b1;
    logic [7:0]  rx_data;
    logic        rx_valid, parity_err, frame_err, noise_err;

    int checks = 0;
    int fails  = 0;
    logic [10:0] exp_q[$];   // {noise, frame, parity, data}
    string       tag_q[$];
    logic [7:0]  last_data = 8'h00;

    always #5 clk = ~clk;

    serial_rx_vote uut (
        .clk(clk), .rst_n(rst_n), .baud_div(baud_div),
        .parity_en(parity_en), .parity_odd(parity_odd), .rxd(rxd),
        .rx_data(rx_data), .rx_valid(rx_valid), .parity_err(parity_err),
        .frame_err(frame_err), .noise_err(noise_err)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one character; gbit selects the glitched bit (-1 none),
    // gspan 1 corrupts the middle sample, 2 the middle and last samples.
    task automatic send(input logic [7:0] d, input int gbit, input int gspan,
                        input logic stop_v, input logic par_flip,
                        input int gap_bits, input string tag);
        logic [10:0] bits;
        logic [7:0]  ed;
        int nb, div, lo, hi;
        div = int'(baud_div);
        bits = '0;
        bits[0] = 1'b0;
        bits[8:1] = d;
        if (parity_en) begin
            bits[9]  = (^d) ^ parity_odd ^ par_flip;
            bits[10] = stop_v;
            nb = 11;
        end else begin
            bits[9] = stop_v;
            nb = 10;
        end
        ed = d;
        if (gspan == 2 && gbit >= 1 && gbit <= 8) ed[gbit-1] = ~d[gbit-1];
        exp_q.push_back({gbit >= 0, ~stop_v, parity_en & par_flip, ed});
        tag_q.push_back(tag);
        last_data = ed;
        lo = 8 * div - 1;
        hi = (gspan == 2) ? 9 * div + 2 : 8 * div + 2;
        for (int b = 0; b < nb; b++) begin
            for (int c = 0; c < 16 * div; c++) begin
                rxd = (b == gbit && c >= lo && c < hi) ? ~bits[b] : bits[b];
                @(negedge clk);
            end
        end
        rxd = 1'b1;
        repeat (gap_bits * 16 * div) @(negedge clk);
    endtask

    // Monitor: compare every delivered character with the queue head.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected strobe", rx_data, 8'h00);
            end else begin
                logic [10:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rx_data == e[7:0], {t, " data"}, rx_data, e[7:0]);
                check(parity_err == e[8], {t, " R7 parity flag"}, {7'd0, parity_err}, {7'd0, e[8]});
                check(frame_err == e[9], {t, " R8 frame flag"}, {7'd0, frame_err}, {7'd0, e[9]});
                check(noise_err == e[10], {t, " R6 noise flag"}, {7'd0, noise_err}, {7'd0, e[10]});
            end
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        check(!rx_valid && rx_data == 8'h00 && !parity_err && !frame_err && !noise_err,
              "R1 reset state", {rx_valid, parity_err, frame_err, noise_err, 4'h0}, 8'h00);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        check(!rx_valid && rx_data == 8'h00, "R1 idle after reset", rx_data, 8'h00);

        send(8'hA5, -1, 1, 1'b1, 1'b0, 2, "R4 clean A5");
        send(8'h3C, -1, 1, 1'b1, 1'b0, 2, "R4 clean 3C");
        send(8'h96, 4, 1, 1'b1, 1'b0, 2, "R6 data glitch");
        send(8'h0F, 1, 2, 1'b1, 1'b0, 2, "R5 majority flip");
        send(8'h6E, 0, 1, 1'b1, 1'b0, 2, "R6 start glitch");
        send(8'hC3, 9, 1, 1'b1, 1'b0, 2, "R6 stop glitch");
        send(8'h55, -1, 1, 1'b0, 1'b0, 2, "R8 low stop");

        // False start: a short low pulse that is high at every start sample.
        rxd = 1'b0;
        repeat (10) @(negedge clk);
        rxd = 1'b1;
        repeat (64) @(negedge clk);
        send(8'h81, -1, 1, 1'b1, 1'b0, 2, "R3 after false start");

        // Back-to-back characters with no idle time.
        send(8'h12, -1, 1, 1'b1, 1'b0, 0, "R10 first");
        send(8'h34, -1, 1, 1'b1, 1'b0, 2, "R10 second");

        parity_en = 1'b1; parity_odd = 1'b0;
        send(8'h07, -1, 1, 1'b1, 1'b0, 2, "R7 even ok");
        send(8'h07, -1, 1, 1'b1, 1'b1, 2, "R7 even bad");
        parity_odd = 1'b1;
        send(8'hB2, -1, 1, 1'b1, 1'b0, 2, "R7 odd ok");
        send(8'hB2, -1, 1, 1'b1, 1'b1, 2, "R7 odd bad");
        send(8'h44, 9, 1, 1'b1, 1'b0, 2, "R6 parity-bit glitch");
        parity_en = 1'b0; parity_odd = 1'b0;

        baud_div = 16'd6;
        repeat (10) @(negedge clk);
        send(8'h5A, -1, 1, 1'b1, 1'b0, 2, "R2 div6 clean");
        send(8'hE1, 3, 1, 1'b1, 1'b0, 2, "R2 div6 glitch");

        // Outputs held between strobes.
        repeat (200) @(negedge clk);
        check(rx_data == last_data && noise_err, "R9 hold", rx_data, last_data);

        check(exp_q.size() == 0, "R3 missing deliveries", 8'(exp_q.size()), 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule